// File: doc/BRIEF.md
# Tiled Texture Address Generator

The block turns a pixel coordinate into a byte offset inside a three-level tiled image. Pixels are grouped into 64-byte micro-tiles. Sixteen micro-tiles form a 1 KB subtile, and four subtiles form a 4 KB tile. Tiles are stored row after row, with row 0 at the bottom of the image. Rows of tiles alternate direction: even rows run left to right and odd rows run right to left. The order of the four subtiles inside a tile also changes between even and odd rows. A texture fetch unit gives the block one coordinate per valid/ready transfer. The matching offset comes out two cycles later through a second valid/ready handshake, and full backpressure holds it there until it is taken.

The same input handshake can start a rectangle walk instead of a single lookup. The walk visits every pixel of the rectangle, with x stepping fastest and then y increasing. It feeds one coordinate per cycle into the pipeline while the input side is held off. The image width and height, given in whole tiles, and the pixel size are configuration inputs. These inputs must stay stable while transfers are in flight. Coordinates outside the image, or an unused pixel-size code, set an error flag that travels with the offset.

Top module: `tiled_addr_gen`

## Requirements
- R1: During and right after reset, out_valid is 0. Once reset is released and the pipeline is empty, in_ready is 1.
- R2: cfg_bpp selects the pixel size: 0 = 1 byte with 8x8-pixel micro-tiles, 1 = 2 bytes with 8x4, 2 = 4 bytes with 4x4. Inside a micro-tile the pixel at local (px, py) is at byte (py*width + px)*bytes, with py counting upward.
- R3: A subtile is 4x4 micro-tiles. The micro-tile at (ux, uy) within its subtile adds (uy*4 + ux)*64 bytes.
- R4: On an even tile row the subtile slots are bottom-left 0, top-left 1, top-right 2, bottom-right 3. Each slot adds slot*1024 bytes.
- R5: On an odd tile row the slots are top-right 0, bottom-right 1, bottom-left 2, top-left 3.
- R6: The tile at column tx of tile row ty adds (ty*W + c)*4096 bytes. Here W is cfg_wtiles, c = tx on even rows and c = W-1-tx on odd rows. The pixel (0,0) sits at the bottom-left and has offset 0.
- R7: out_err is 1 when x is at or beyond W tile widths, when y is at or beyond cfg_htiles tile heights, or when cfg_bpp is 3. Every offset without an error is below W*H*4096.
- R8: When out_ready is held at 1, a single coordinate accepted on one clock edge appears on the outputs after the second following edge, and not after the first.
- R9: While out_valid is 1 and out_ready is 0, out_valid, out_offset and out_err hold steady, and no result is lost or repeated.
- R10: A transfer with in_walk = 1 and a non-zero size produces in_w*in_h results in raster order: x from in_x upward first, then y from in_y upward. in_ready stays 0 until the last coordinate has entered the pipeline. A walk with a zero width or height produces nothing.
- R11: Walking a whole image gives every pixel-aligned offset in [0, W*H*4096) exactly once, for each pixel size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_wtiles | input | WT_W | Image width in tiles |
| cfg_htiles | input | WT_W | Image height in tiles |
| cfg_bpp | input | 2 | Pixel size code (0: 1 B, 1: 2 B, 2: 4 B, 3: unused) |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request accepted when high together with in_valid |
| in_walk | input | 1 | 1: rectangle walk, 0: single coordinate |
| in_x | input | X_W | Pixel x, or the rectangle's left edge |
| in_y | input | X_W | Pixel y counted from the bottom, or the rectangle's lower edge |
| in_w | input | X_W | Rectangle width in pixels (walk only) |
| in_h | input | X_W | Rectangle height in pixels (walk only) |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Result consumed when high together with out_valid |
| out_offset | output | OFS_W | Byte offset of the pixel |
| out_err | output | 1 | Coordinate out of the image or unused pixel size |

## Verification
The checker watches properties that hold on every cycle. These are: the output holds steady while stalled, an accepted single lookup arrives after two cycles, the input stays closed after a walk starts, error-free offsets stay inside the image and are aligned for 4-byte pixels, and the unused pixel-size code always sets the error flag. Only the bench's scenarios can show that the offsets themselves are right. Those scenarios cover the snaking tile order, the swapped subtile order on odd rows, the micro-tile shapes for each pixel size, and walks that cross the image edge. Full-image walks then confirm that each pixel size covers the image as a permutation with no gaps or repeats.

// File: rtl/tiled_addr_pkg.sv
package tiled_addr_pkg;

   typedef enum logic [1:0] {
      BPP_1B  = 2'd0,
      BPP_2B  = 2'd1,
      BPP_4B  = 2'd2,
      BPP_RSV = 2'd3
   } bpp_e;

   localparam int TILE_BYTES_LG = 12;
   localparam int SUB_BYTES_LG  = 10;
   localparam int UT_BYTES_LG   = 6;

   // log2 of the micro-tile width in pixels for a given log2(bytes per pixel)
   function automatic logic [2:0] ut_w_lg(input logic [1:0] bl);
      return (bl == 2'd2) ? 3'd2 : 3'd3;
   endfunction

   // log2 of the micro-tile height in pixels
   function automatic logic [2:0] ut_h_lg(input logic [1:0] bl);
      return (bl == 2'd0) ? 3'd3 : 3'd2;
   endfunction

   // storage slot of subtile (sx right, sy upper) within its tile;
   // the order on odd rows is the even order with the upper slot bit flipped
   function automatic logic [1:0] subtile_slot(input logic sx, input logic sy, input logic odd);
      return {sx ^ odd, sx ^ sy};
   endfunction

endpackage

// File: rtl/tiled_walker.sv
module tiled_walker #(
   parameter int X_W = 12
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           in_valid,
   input  logic           in_walk,
   input  logic [X_W-1:0] in_x,
   input  logic [X_W-1:0] in_y,
   input  logic [X_W-1:0] in_w,
   input  logic [X_W-1:0] in_h,
   input  logic           take,
   output logic           in_ready,
   output logic           feed_valid,
   output logic [X_W:0]   feed_x,
   output logic [X_W:0]   feed_y,
   output logic           busy
);
   localparam int XL = X_W + 1;
   localparam logic [XL-1:0] ONE_X = XL'(1);

   logic          active;
   logic [XL-1:0] cx, cy, x0, xe, ye;
   logic          start;

   assign in_ready   = !active && take;
   assign feed_valid = active || (in_valid && !in_walk);
   assign feed_x     = active ? cx : XL'(in_x);
   assign feed_y     = active ? cy : XL'(in_y);
   assign busy       = active;
   assign start      = in_valid && in_ready && in_walk && (in_w != '0) && (in_h != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         cx     <= '0;
         cy     <= '0;
         x0     <= '0;
         xe     <= '0;
         ye     <= '0;
      end else if (start) begin
         active <= 1'b1;
         cx     <= XL'(in_x);
         cy     <= XL'(in_y);
         x0     <= XL'(in_x);
         xe     <= XL'(in_x) + XL'(in_w) - ONE_X;
         ye     <= XL'(in_y) + XL'(in_h) - ONE_X;
      end else if (active && take) begin
         if (cx == xe) begin
            cx <= x0;
            if (cy == ye) begin
               active <= 1'b0;
            end else begin
               cy <= cy + ONE_X;
            end
         end else begin
            cx <= cx + ONE_X;
         end
      end
   end

endmodule

// File: rtl/tiled_split.sv
module tiled_split
   import tiled_addr_pkg::*;
#(
   parameter int X_W  = 12,
   parameter int WT_W = 7
) (
   input  logic [X_W:0]    px_x,
   input  logic [X_W:0]    px_y,
   input  logic [WT_W-1:0] wt,
   input  logic [WT_W-1:0] ht,
   input  logic [1:0]      bpp,
   output logic [WT_W-1:0] tile_row,
   output logic [WT_W-1:0] tile_col,
   output logic [1:0]      slot,
   output logic [3:0]      utile,
   output logic [5:0]      pix_b,
   output logic            err
);
   localparam int XL = X_W + 1;
   localparam logic [WT_W-1:0] ONE_T = WT_W'(1);

   logic [1:0]      bl;
   logic [2:0]      wl, hl;
   logic [1:0]      ux, uy;
   logic [2:0]      pxl, pyl;
   logic [5:0]      pix;
   logic            sx, sy, odd_row, rsv;
   logic [WT_W-1:0] tx;
   logic [XL-1:0]   lim_x, lim_y;

   always_comb begin
      rsv      = (bpp == BPP_RSV);
      bl       = rsv ? 2'd2 : bpp;
      wl       = ut_w_lg(bl);
      hl       = ut_h_lg(bl);
      // tile coordinates: a tile is 8 micro-tiles on each side
      tx       = WT_W'(px_x >> (wl + 3'd3));
      tile_row = WT_W'(px_y >> (hl + 3'd3));
      odd_row  = tile_row[0];
      // subtile half within the tile
      sx       = 1'(px_x >> (wl + 3'd2));
      sy       = 1'(px_y >> (hl + 3'd2));
      // micro-tile within the subtile
      ux       = 2'(px_x >> wl);
      uy       = 2'(px_y >> hl);
      // pixel within the micro-tile
      pxl      = px_x[2:0] & ((wl == 3'd3) ? 3'b111 : 3'b011);
      pyl      = px_y[2:0] & ((hl == 3'd3) ? 3'b111 : 3'b011);
      pix      = (6'(pyl) << wl) | 6'(pxl);
      pix_b    = pix << bl;
      slot     = subtile_slot(sx, sy, odd_row);
      utile    = {uy, ux};
      tile_col = odd_row ? (wt - ONE_T - tx) : tx;
      lim_x    = XL'(wt) << (wl + 3'd3);
      lim_y    = XL'(ht) << (hl + 3'd3);
      err      = (px_x >= lim_x) || (px_y >= lim_y) || rsv;
   end

endmodule

// File: rtl/tiled_join.sv
module tiled_join #(
   parameter int WT_W     = 7,
   parameter int OFS_W    = 32,
   parameter int MUL_IMPL = 0
) (
   input  logic [WT_W-1:0]  tile_row,
   input  logic [WT_W-1:0]  tile_col,
   input  logic [WT_W-1:0]  wt,
   input  logic [1:0]       slot,
   input  logic [3:0]       utile,
   input  logic [5:0]       pix_b,
   output logic [OFS_W-1:0] offset
);
   localparam int PW = 2 * WT_W;
   localparam int CW = PW + 12;

   logic [PW-1:0] row_base;
   logic [PW-1:0] tile_idx;

   generate
      if (MUL_IMPL == 0) begin : g_mul
         assign row_base = PW'(tile_row) * PW'(wt);
      end else begin : g_shadd
         logic [PW-1:0] part [WT_W];
         logic [PW-1:0] acc;
         for (genvar i = 0; i < WT_W; i++) begin : g_part
            assign part[i] = wt[i] ? (PW'(tile_row) << i) : '0;
         end
         always_comb begin
            acc = '0;
            for (int i = 0; i < WT_W; i++) begin
               acc = acc + part[i];
            end
         end
         assign row_base = acc;
      end
   endgenerate

   assign tile_idx = row_base + PW'(tile_col);

   logic [CW-1:0] packed_ofs;
   assign packed_ofs = {tile_idx, slot, utile, pix_b};

   generate
      if (OFS_W == CW) begin : g_exact
         assign offset = packed_ofs;
      end else begin : g_wide
         assign offset = {{(OFS_W - CW){1'b0}}, packed_ofs};
      end
   endgenerate

endmodule

// File: rtl/tiled_addr_gen.sv
module tiled_addr_gen
   import tiled_addr_pkg::*;
#(
   parameter int X_W      = 12,
   parameter int WT_W     = 7,
   parameter int OFS_W    = 32,
   parameter int MUL_IMPL = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WT_W-1:0]  cfg_wtiles,
   input  logic [WT_W-1:0]  cfg_htiles,
   input  logic [1:0]       cfg_bpp,
   input  logic             in_valid,
   output logic             in_ready,
   input  logic             in_walk,
   input  logic [X_W-1:0]   in_x,
   input  logic [X_W-1:0]   in_y,
   input  logic [X_W-1:0]   in_w,
   input  logic [X_W-1:0]   in_h,
   output logic             out_valid,
   input  logic             out_ready,
   output logic [OFS_W-1:0] out_offset,
   output logic             out_err
);
   localparam int XL = X_W + 1;

   // elaboration-time parameter checks
   if (XL < WT_W + 6) begin : g_bad_xw
      $fatal(1, "X_W too small to span the widest image");
   end
   if (OFS_W < 2 * WT_W + 12) begin : g_bad_ofs
      $fatal(1, "OFS_W too small for the largest image");
   end
   if (MUL_IMPL != 0 && MUL_IMPL != 1) begin : g_bad_mul
      $fatal(1, "MUL_IMPL must be 0 or 1");
   end

   // handshake readiness through the two stages
   logic v1, v2;
   logic s1_ready, s2_ready;
   assign s2_ready = !v2 || out_ready;
   assign s1_ready = !v1 || s2_ready;

   // coordinate source
   logic          feed_valid;
   logic [XL-1:0] feed_x, feed_y;
   logic          walk_busy;

   tiled_walker #(.X_W(X_W)) u_walk (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_valid   (in_valid),
      .in_walk    (in_walk),
      .in_x       (in_x),
      .in_y       (in_y),
      .in_w       (in_w),
      .in_h       (in_h),
      .take       (s1_ready),
      .in_ready   (in_ready),
      .feed_valid (feed_valid),
      .feed_x     (feed_x),
      .feed_y     (feed_y),
      .busy       (walk_busy)
   );

   // stage 1: field extraction
   logic [WT_W-1:0] sp_row, sp_col;
   logic [1:0]      sp_slot;
   logic [3:0]      sp_ut;
   logic [5:0]      sp_pix;
   logic            sp_err;

   tiled_split #(.X_W(X_W), .WT_W(WT_W)) u_split (
      .px_x     (feed_x),
      .px_y     (feed_y),
      .wt       (cfg_wtiles),
      .ht       (cfg_htiles),
      .bpp      (cfg_bpp),
      .tile_row (sp_row),
      .tile_col (sp_col),
      .slot     (sp_slot),
      .utile    (sp_ut),
      .pix_b    (sp_pix),
      .err      (sp_err)
   );

   logic [WT_W-1:0] r1_row, r1_col, r1_wt;
   logic [1:0]      r1_slot;
   logic [3:0]      r1_ut;
   logic [5:0]      r1_pix;
   logic            r1_err;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v1 <= 1'b0;
      end else if (s1_ready) begin
         v1 <= feed_valid;
      end
   end

   always_ff @(posedge clk) begin
      if (s1_ready && feed_valid) begin
         r1_row  <= sp_row;
         r1_col  <= sp_col;
         r1_wt   <= cfg_wtiles;
         r1_slot <= sp_slot;
         r1_ut   <= sp_ut;
         r1_pix  <= sp_pix;
         r1_err  <= sp_err;
      end
   end

   // stage 2: offset assembly
   logic [OFS_W-1:0] jn_ofs;

   tiled_join #(.WT_W(WT_W), .OFS_W(OFS_W), .MUL_IMPL(MUL_IMPL)) u_join (
      .tile_row (r1_row),
      .tile_col (r1_col),
      .wt       (r1_wt),
      .slot     (r1_slot),
      .utile    (r1_ut),
      .pix_b    (r1_pix),
      .offset   (jn_ofs)
   );

   logic [OFS_W-1:0] r2_ofs;
   logic             r2_err;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v2 <= 1'b0;
      end else if (s2_ready) begin
         v2 <= v1;
      end
   end

   always_ff @(posedge clk) begin
      if (s2_ready && v1) begin
         r2_ofs <= jn_ofs;
         r2_err <= r1_err;
      end
   end

   assign out_valid  = v2;
   assign out_offset = r2_ofs;
   assign out_err    = r2_err;

endmodule

// File: rtl/tiled_addr_chk.sv
module tiled_addr_chk #(
   parameter int X_W   = 12,
   parameter int WT_W  = 7,
   parameter int OFS_W = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic [WT_W-1:0]  cfg_wtiles,
   input logic [WT_W-1:0]  cfg_htiles,
   input logic [1:0]       cfg_bpp,
   input logic             in_valid,
   input logic             in_ready,
   input logic             in_walk,
   input logic [X_W-1:0]   in_w,
   input logic [X_W-1:0]   in_h,
   input logic             out_valid,
   input logic             out_ready,
   input logic [OFS_W-1:0] out_offset,
   input logic             out_err
);
   logic single_q;
   logic [OFS_W-1:0] img_bytes;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) single_q <= 1'b0;
      else        single_q <= in_valid && in_ready && !in_walk;
   end

   assign img_bytes = (OFS_W'(cfg_wtiles) * OFS_W'(cfg_htiles)) << 12;

   AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_offset) && $stable(out_err)); // R9

   AST_TWO_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      single_q && out_ready |=> out_valid); // R8

   AST_WALK_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ready && in_walk && (in_w != '0) && (in_h != '0) |=> !in_ready); // R10

   AST_IN_IMAGE: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_err |-> out_offset < img_bytes); // R7

   AST_RSV_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && (cfg_bpp == 2'd3) |-> out_err); // R7

   AST_WORD_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_err && (cfg_bpp == 2'd2) |-> out_offset[1:0] == 2'b00); // R2

endmodule

bind tiled_addr_gen tiled_addr_chk #(.X_W(X_W), .WT_W(WT_W), .OFS_W(OFS_W)) u_chk (.*);

// File: tb/tiled_addr_gen_bench.sv
module tiled_addr_gen_bench;
   localparam int CLK_PERIOD = 10;
   localparam int X_W   = 12;
   localparam int WT_W  = 7;
   localparam int OFS_W = 32;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [WT_W-1:0]  cfg_wtiles = '0;
   logic [WT_W-1:0]  cfg_htiles = '0;
   logic [1:0]       cfg_bpp = '0;
   logic             in_valid = 1'b0;
   logic             in_ready;
   logic             in_walk = 1'b0;
   logic [X_W-1:0]   in_x = '0, in_y = '0, in_w = '0, in_h = '0;
   logic             out_valid;
   logic             out_ready = 1'b1;
   logic [OFS_W-1:0] out_offset;
   logic             out_err;

   always #(CLK_PERIOD / 2) clk = ~clk;

   tiled_addr_gen #(.X_W(X_W), .WT_W(WT_W), .OFS_W(OFS_W)) u_tiled_addr_gen (
      .clk(clk), .rst_n(rst_n), .cfg_wtiles(cfg_wtiles), .cfg_htiles(cfg_htiles),
      .cfg_bpp(cfg_bpp), .in_valid(in_valid), .in_ready(in_ready), .in_walk(in_walk),
      .in_x(in_x), .in_y(in_y), .in_w(in_w), .in_h(in_h), .out_valid(out_valid),
      .out_ready(out_ready), .out_offset(out_offset), .out_err(out_err));

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // layout model built from the stated geometry with division and remainder
   function automatic longint model(input int x, input int y, input int W, input int b);
      int uw, uh, tw, th, ty, tx, col, lx, ly, sx, sy, slot, ux, uy, px, py;
      uw = (b == 4) ? 4 : 8;
      uh = (b == 1) ? 8 : 4;
      tw = uw * 8;  th = uh * 8;
      ty = y / th;  tx = x / tw;
      col = (ty % 2 == 1) ? (W - 1 - tx) : tx;
      lx = x % tw;  ly = y % th;
      sx = lx / (uw * 4);  sy = ly / (uh * 4);
      if (ty % 2 == 0) slot = (sx == 0) ? ((sy == 0) ? 0 : 1) : ((sy == 1) ? 2 : 3);
      else             slot = (sx == 1) ? ((sy == 1) ? 0 : 1) : ((sy == 0) ? 2 : 3);
      ux = (lx % (uw * 4)) / uw;  uy = (ly % (uh * 4)) / uh;
      px = lx % uw;  py = ly % uh;
      return longint'(ty * W + col) * 4096 + slot * 1024 + (uy * 4 + ux) * 64 + (py * uw + px) * b;
   endfunction

   function automatic bit model_err(input int x, input int y, input int W, input int H, input int b);
      int tw, th;
      tw = ((b == 4) ? 4 : 8) * 8;
      th = ((b == 1) ? 8 : 4) * 8;
      return (x >= W * tw) || (y >= H * th);
   endfunction

   function automatic logic [1:0] bcode(input int b);
      return (b == 1) ? 2'd0 : (b == 2) ? 2'd1 : 2'd2;
   endfunction

   // backpressure generator
   bit stall_en = 0;
   logic [15:0] lfsr = 16'hACE1;
   always @(posedge clk) begin
      #1;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      out_ready = stall_en ? (lfsr[0] | lfsr[5]) : 1'b1;
   end

   // walk monitor
   bit     m_active = 0;
   bit     m_sums = 0;
   int     m_x0, m_y0, m_w, m_h, m_W, m_H, m_b, m_total;
   int     m_idx = 0;
   longint s1, s2;
   bit     hold_pend = 0;
   logic [OFS_W-1:0] held_ofs;
   logic   held_err;

   always @(negedge clk) begin
      if (rst_n) begin
         if (hold_pend) begin
            chk(out_valid === 1'b1, "R9 stalled valid", longint'(out_valid), 1);
            chk(out_offset === held_ofs && out_err === held_err, "R9 stalled data",
                longint'(out_offset), longint'(held_ofs));
         end
         hold_pend = out_valid && !out_ready;
         held_ofs  = out_offset;
         held_err  = out_err;
         if (out_valid && out_ready && m_active) begin
            if (m_idx >= m_total) begin
               chk(0, "R10 extra output", m_idx + 1, m_total);
            end else begin
               int x, y;
               bit e;
               x = m_x0 + m_idx % m_w;
               y = m_y0 + m_idx / m_w;
               e = model_err(x, y, m_W, m_H, m_b);
               chk(out_err === e, "R7 walk error flag", longint'(out_err), longint'(e));
               if (!e) begin
                  longint exp_o;
                  exp_o = model(x, y, m_W, m_b);
                  chk(longint'(out_offset) == exp_o, "R10 walk offset", longint'(out_offset), exp_o);
                  if (m_sums) begin
                     longint k;
                     k = longint'(out_offset) / m_b;
                     s1 += k;
                     s2 += k * k;
                  end
               end
            end
            m_idx++;
         end
      end
   end

   task automatic set_cfg(input int W, input int H, input logic [1:0] code);
      @(negedge clk);
      cfg_wtiles = WT_W'(W);
      cfg_htiles = WT_W'(H);
      cfg_bpp    = code;
   endtask

   task automatic single(input int x, input int y, input bit exp_err, input longint exp_o, input string req);
      @(negedge clk);
      in_valid = 1; in_walk = 0; in_x = X_W'(x); in_y = X_W'(y);
      while (!in_ready) @(negedge clk);
      @(posedge clk);
      @(negedge clk);
      in_valid = 0;
      chk(out_valid === 1'b0, "R8 not after one cycle", longint'(out_valid), 0);
      @(negedge clk);
      chk(out_valid === 1'b1, "R8 valid after two cycles", longint'(out_valid), 1);
      chk(out_err === exp_err, {req, " error flag"}, longint'(out_err), longint'(exp_err));
      if (!exp_err) chk(longint'(out_offset) == exp_o, req, longint'(out_offset), exp_o);
   endtask

   task automatic run_walk(input int x0, input int y0, input int w, input int h,
                           input int W, input int H, input int b, input bit stall, input bit sums);
      int guard;
      m_x0 = x0; m_y0 = y0; m_w = (w == 0) ? 1 : w; m_h = h;
      m_W = W; m_H = H; m_b = b; m_total = w * h;
      m_idx = 0; s1 = 0; s2 = 0; m_sums = sums; m_active = 1;
      stall_en = stall;
      @(negedge clk);
      in_valid = 1; in_walk = 1;
      in_x = X_W'(x0); in_y = X_W'(y0); in_w = X_W'(w); in_h = X_W'(h);
      while (!in_ready) @(negedge clk);
      @(posedge clk);
      @(negedge clk);
      in_valid = 0; in_walk = 0;
      if (m_total > 0) chk(in_ready === 1'b0, "R10 input closed during walk", longint'(in_ready), 0);
      guard = 0;
      while (m_idx < m_total && guard < m_total * 8 + 50) begin
         @(negedge clk);
         guard++;
      end
      stall_en = 0;
      repeat (6) @(negedge clk);
      chk(m_idx == m_total, "R10 walk result count", m_idx, m_total);
      chk(in_ready === 1'b1, "R10 input reopens", longint'(in_ready), 1);
      if (sums) begin
         longint n;
         n = longint'(W) * H * 4096 / b;
         chk(s1 == n * (n - 1) / 2, "R11 offset sum", s1, n * (n - 1) / 2);
         chk(s2 == (n - 1) * n * (2 * n - 1) / 6, "R11 offset square sum", s2, (n - 1) * n * (2 * n - 1) / 6);
      end
      m_active = 0;
      m_sums = 0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(out_valid === 1'b0, "R1 out_valid in reset", longint'(out_valid), 0);
      rst_n = 1;
      @(negedge clk);
      chk(out_valid === 1'b0, "R1 out_valid after reset", longint'(out_valid), 0);
      chk(in_ready === 1'b1, "R1 in_ready after reset", longint'(in_ready), 1);

      // 4-byte pixels, 2x2 tiles
      set_cfg(2, 2, 2'd2);
      single(0, 0, 0, 0, "R6 origin");
      single(1, 0, 0, 4, "R2 4B next pixel");
      single(0, 1, 0, 16, "R2 4B pixel row up");
      single(4, 0, 0, 64, "R3 next micro-tile");
      single(0, 4, 0, 256, "R3 micro-tile row up");
      single(0, 16, 0, 1024, "R4 top-left slot");
      single(16, 16, 0, 2048, "R4 top-right slot");
      single(16, 0, 0, 3072, "R4 bottom-right slot");
      single(32, 0, 0, 4096, "R6 second tile even row");
      single(0, 32, 0, 14336, "R5 R6 odd row bottom-left");
      single(48, 48, 0, 8192, "R5 odd row top-right");
      single(63, 63, 0, 9212, "R5 last pixel");
      single(64, 0, 1, 0, "R7 x past edge");
      single(0, 64, 1, 0, "R7 y past edge");

      // 1-byte and 2-byte micro-tile shapes
      set_cfg(2, 2, 2'd0);
      single(1, 0, 0, 1, "R2 1B next pixel");
      single(0, 1, 0, 8, "R2 1B pixel row up");
      single(8, 0, 0, 64, "R3 1B next micro-tile");
      set_cfg(2, 2, 2'd1);
      single(1, 0, 0, 2, "R2 2B next pixel");
      single(0, 1, 0, 16, "R2 2B pixel row up");
      single(0, 4, 0, 256, "R3 2B micro-tile row up");
      set_cfg(2, 2, 2'd3);
      single(0, 0, 1, 0, "R7 unused pixel size");

      // full-image sweeps with backpressure
      for (int i = 0; i < 3; i++) begin
         int b;
         b = (i == 0) ? 4 : (i == 1) ? 2 : 1;
         set_cfg(2, 2, bcode(b));
         run_walk(0, 0, (b == 4) ? 64 : 128, (b == 1) ? 128 : 64, 2, 2, b, 1, 1);
      end
      set_cfg(3, 2, 2'd2);
      run_walk(0, 0, 96, 64, 3, 2, 4, 0, 1);

      // rectangle across the image corner
      set_cfg(2, 2, 2'd2);
      run_walk(60, 62, 8, 4, 2, 2, 4, 1, 0);
      // empty walk
      run_walk(5, 5, 0, 3, 2, 2, 4, 0, 0);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule